// File: doc/BRIEF.md
# CAN Message Buffer Manager

This block sits between a CAN protocol engine and the CPU register bus and owns a bank of fifteen message buffers. Each buffer holds an identifier, frame flags, up to eight data bytes, a capture time stamp and a status code. Software sets each buffer to receive or transmit through single-cycle word or byte writes. The block then works on its own. It files each received frame into a buffer that passes acceptance filtering. It offers the engine the most urgent pending transmit buffer. It also answers remote frames and switches buffers to receive after a remote frame has been sent.

Two acceptance masks are held in a configuration page. One covers buffers 0 to 13. The other covers only buffer 14, which can be opened wide to act as a catch-all path. A sixteen-bit counter runs on every clock, and its value is stored into a buffer whenever that buffer receives or completes a frame.

Top module: `can_mbuf_mgr`

## Requirements
- R1: The CPU address is {page[3:0], word[2:0]}. Pages 0 to 14 are buffers. Buffer words are: 0 = id[15:0]; 1 = {rtr, ide, dir, id[28:16]}; 2..5 = data bytes, little-endian (word 2 = {byte1, byte0}); 6 = {prio[3:0], auto, 3'b0, dlc[3:0], 1'b0, status[2:0]}; 7 = time stamp (read-only). Page 15 holds: word 0/1 = mask A low/high, word 2/3 = mask B low/high, word 4 = the live counter. Reads are combinational. A write takes effect at the next clock edge. cpu_be[0] and cpu_be[1] enable the low and high byte.
- R2: Status codes are empty=0, full=1, overrun=2, transmit pending=3, transmit busy=4. dir=0 means receive. After reset every buffer is an empty receive buffer and both masks are all ones.
- R3: A buffer accepts a frame only if its ide bit equals the frame's ide and the identifiers agree on every bit where the mask holds 1. Buffers 0 to 13 use mask A and buffer 14 uses mask B.
- R4: A received frame goes to the lowest-numbered receive buffer that matches and has status empty. That buffer takes the frame's id, ide, rtr, dlc and data, and its status becomes full.
- R5: If receive buffers match but none is empty, the frame is dropped. The lowest matching buffer changes to overrun and its contents stay the same.
- R6: Only transmit buffers with status pending take part in arbitration. The smallest prio value wins, and on equal prio the lower index wins. tx_req is high only while no transmission is in progress, and tx_id/tx_data show the winner.
- R7: tx_start while tx_req is high makes the winner busy (status 4) and keeps its frame on the tx outputs. tx_done sets its status to empty and captures the time stamp.
- R8: A transmit buffer with rtr=1 and auto=1 returns to a receive buffer (dir=0, empty) when its transmission completes.
- R9: A received remote frame whose ide and full identifier equal those of an empty transmit buffer with auto=1 makes that buffer pending. The lowest such buffer is chosen, and the frame is not stored in any receive buffer.
- R10: The time stamp counter is zero during reset and increases by one on every clock. The value stored for an event is the counter value at the clock edge that registers the event.
- R11: For standard frames (ide=0) the identifier sits in id[28:18], and only those bits are compared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cpu_addr | input | 7 | CPU word address {page, word} |
| cpu_wr | input | 1 | CPU write strobe |
| cpu_be | input | 2 | Byte enables for the write |
| cpu_wdata | input | 16 | CPU write data |
| cpu_rdata | output | 16 | CPU read data (combinational) |
| rx_valid | input | 1 | Received frame strobe |
| rx_id | input | 29 | Received identifier |
| rx_ide | input | 1 | Received frame is extended |
| rx_rtr | input | 1 | Received frame is remote |
| rx_dlc | input | 4 | Received data length |
| rx_data | input | 64 | Received data bytes |
| tx_req | output | 1 | A frame is offered for transmission |
| tx_id | output | 29 | Offered identifier |
| tx_ide | output | 1 | Offered frame is extended |
| tx_rtr | output | 1 | Offered frame is remote |
| tx_dlc | output | 4 | Offered data length |
| tx_data | output | 64 | Offered data bytes |
| tx_start | input | 1 | Engine takes the offered frame |
| tx_done | input | 1 | Engine finished the frame in progress |

## Verification
The hardest state to reach is the remote-frame reply path. The bench needs a transmit buffer that is empty with auto set, and an ordinary receive buffer with the same identifier that would otherwise take the frame. That is the only way to see that the remote frame is diverted and not stored. The bench builds this after the arbitration tests have drained every pending buffer. It then sends the remote frame and checks that the transmit buffer is pending and offered on the tx outputs while the receive buffer stays empty. The overrun path is reached the same way: two matching buffers are filled first, and a third frame follows.

// File: rtl/canmb_pkg.sv
package canmb_pkg;
  localparam int IDW  = 29;
  localparam int DATW = 64;
  localparam int TSW  = 16;

  typedef enum logic [2:0] {
    ST_EMPTY  = 3'd0,
    ST_FULL   = 3'd1,
    ST_OVR    = 3'd2,
    ST_TXPEND = 3'd3,
    ST_TXBUSY = 3'd4
  } mb_st_e;

  typedef struct packed {
    logic [IDW-1:0]  id;
    logic            ide;
    logic            rtr;
    logic            dir;    // 1 = transmit
    logic            autor;  // automatic remote handling
    logic [3:0]      dlc;
    logic [3:0]      prio;
    logic [DATW-1:0] data;
    logic [TSW-1:0]  ts;
    mb_st_e          st;
  } mbuf_t;

  // identifier comparison under a mask; standard frames use bits 28:18
  function automatic logic id_match(input logic [IDW-1:0] fid, input logic fide,
                                    input logic [IDW-1:0] bid, input logic bide,
                                    input logic [IDW-1:0] mask);
    logic [IDW-1:0] m;
    m = fide ? mask : {mask[IDW-1:18], 18'b0};
    return (fide == bide) && (((fid ^ bid) & m) == '0);
  endfunction
endpackage

// File: rtl/mb_tstamp.sv
module mb_tstamp #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  output logic [W-1:0] count
);
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) count <= '0;
    else        count <= count + 1'b1;
endmodule

// File: rtl/mb_accept.sv
module mb_accept
  import canmb_pkg::*;
#(
  parameter int NBUF = 15
) (
  input  mbuf_t [NBUF-1:0] bufs,
  input  logic [IDW-1:0]   mask_a,
  input  logic [IDW-1:0]   mask_b,
  input  logic [IDW-1:0]   fid,
  input  logic             fide,
  output logic [NBUF-1:0]  rx_hit,
  output logic [NBUF-1:0]  ar_hit
);
  for (genvar g = 0; g < NBUF; g++) begin : g_buf
    logic [IDW-1:0] msk;
    assign msk       = (g == NBUF-1) ? mask_b : mask_a;
    assign rx_hit[g] = !bufs[g].dir && id_match(fid, fide, bufs[g].id, bufs[g].ide, msk);
    assign ar_hit[g] = bufs[g].dir && bufs[g].autor && (bufs[g].st == ST_EMPTY) &&
                       id_match(fid, fide, bufs[g].id, bufs[g].ide, '1);
  end
endmodule

// File: rtl/mb_txarb.sv
module mb_txarb
  import canmb_pkg::*;
#(
  parameter int NBUF = 15,
  localparam int BIW = $clog2(NBUF + 1)
) (
  input  mbuf_t [NBUF-1:0] bufs,
  output logic             sel_vld,
  output logic [BIW-1:0]   sel_idx
);
  logic [3:0] best;
  always_comb begin
    sel_vld = 1'b0;
    sel_idx = '0;
    best    = '1;
    for (int i = 0; i < NBUF; i++) begin
      if (bufs[i].dir && bufs[i].st == ST_TXPEND && (!sel_vld || bufs[i].prio < best)) begin
        sel_vld = 1'b1;
        sel_idx = BIW'(i);
        best    = bufs[i].prio;
      end
    end
  end
endmodule

// File: rtl/can_mbuf_mgr.sv
module can_mbuf_mgr
  import canmb_pkg::*;
#(
  parameter int NBUF = 15,
  localparam int BIW = $clog2(NBUF + 1),
  localparam int AW  = BIW + 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [AW-1:0]   cpu_addr,
  input  logic            cpu_wr,
  input  logic [1:0]      cpu_be,
  input  logic [15:0]     cpu_wdata,
  output logic [15:0]     cpu_rdata,
  input  logic            rx_valid,
  input  logic [IDW-1:0]  rx_id,
  input  logic            rx_ide,
  input  logic            rx_rtr,
  input  logic [3:0]      rx_dlc,
  input  logic [DATW-1:0] rx_data,
  output logic            tx_req,
  output logic [IDW-1:0]  tx_id,
  output logic            tx_ide,
  output logic            tx_rtr,
  output logic [3:0]      tx_dlc,
  output logic [DATW-1:0] tx_data,
  input  logic            tx_start,
  input  logic            tx_done
);
  localparam logic [BIW-1:0] CFG_PAGE = BIW'(NBUF);

  mbuf_t [NBUF-1:0] mb;
  logic [IDW-1:0]   mask_a, mask_b;
  logic [TSW-1:0]   ts_now;
  logic [NBUF-1:0]  rx_hit, ar_hit, free_hit;
  logic             sel_vld, busy_vld;
  logic [BIW-1:0]   sel_idx, busy_idx, cur_idx;
  logic [BIW-1:0]   store_idx, ovr_idx, sched_idx;
  // named events for the checker
  logic             rx_store, rx_ovr, rtr_sched, tx_launch, tx_finish;
  logic [BIW-1:0]   page;
  logic [2:0]       word;
  logic [15:0]      bmask, wr_merged;

  function automatic logic [BIW-1:0] first_set(input logic [NBUF-1:0] v);
    logic [BIW-1:0] r;
    r = '0;
    for (int i = NBUF-1; i >= 0; i--) if (v[i]) r = BIW'(i);
    return r;
  endfunction

  function automatic logic [15:0] rd_word(input mbuf_t b, input logic [2:0] w);
    case (w)
      3'd0: return b.id[15:0];
      3'd1: return {b.rtr, b.ide, b.dir, b.id[28:16]};
      3'd2: return b.data[15:0];
      3'd3: return b.data[31:16];
      3'd4: return b.data[47:32];
      3'd5: return b.data[63:48];
      3'd6: return {b.prio, b.autor, 3'b000, b.dlc, 1'b0, b.st};
      default: return b.ts;
    endcase
  endfunction

  function automatic mbuf_t wr_word(input mbuf_t b, input logic [2:0] w, input logic [15:0] v);
    mbuf_t r;
    r = b;
    case (w)
      3'd0: r.id[15:0] = v;
      3'd1: begin r.rtr = v[15]; r.ide = v[14]; r.dir = v[13]; r.id[28:16] = v[12:0]; end
      3'd2: r.data[15:0]  = v;
      3'd3: r.data[31:16] = v;
      3'd4: r.data[47:32] = v;
      3'd5: r.data[63:48] = v;
      3'd6: begin r.prio = v[15:12]; r.autor = v[11]; r.dlc = v[7:4]; r.st = mb_st_e'(v[2:0]); end
      default: ;
    endcase
    return r;
  endfunction

  mb_tstamp #(.W(TSW)) i_ts (.clk(clk), .rst_n(rst_n), .count(ts_now));

  mb_accept #(.NBUF(NBUF)) i_acc (
    .bufs(mb), .mask_a(mask_a), .mask_b(mask_b), .fid(rx_id), .fide(rx_ide),
    .rx_hit(rx_hit), .ar_hit(ar_hit));

  mb_txarb #(.NBUF(NBUF)) i_arb (.bufs(mb), .sel_vld(sel_vld), .sel_idx(sel_idx));

  for (genvar g = 0; g < NBUF; g++) begin : g_free
    assign free_hit[g] = rx_hit[g] && (mb[g].st == ST_EMPTY);
  end

  assign rtr_sched = rx_valid && rx_rtr && (|ar_hit);
  assign rx_store  = rx_valid && !rtr_sched && (|free_hit);
  assign rx_ovr    = rx_valid && !rtr_sched && !(|free_hit) && (|rx_hit);
  assign store_idx = first_set(free_hit);
  assign ovr_idx   = first_set(rx_hit);
  assign sched_idx = first_set(ar_hit);

  assign tx_req    = sel_vld && !busy_vld;
  assign tx_launch = tx_req && tx_start;
  assign tx_finish = busy_vld && tx_done;
  assign cur_idx   = busy_vld ? busy_idx : sel_idx;
  assign tx_id     = mb[cur_idx].id;
  assign tx_ide    = mb[cur_idx].ide;
  assign tx_rtr    = mb[cur_idx].rtr;
  assign tx_dlc    = mb[cur_idx].dlc;
  assign tx_data   = mb[cur_idx].data;

  assign page = cpu_addr[AW-1:3];
  assign word = cpu_addr[2:0];

  always_comb begin
    cpu_rdata = '0;
    if (page < CFG_PAGE) cpu_rdata = rd_word(mb[page], word);
    else if (page == CFG_PAGE) begin
      case (word)
        3'd0: cpu_rdata = mask_a[15:0];
        3'd1: cpu_rdata = {3'b000, mask_a[28:16]};
        3'd2: cpu_rdata = mask_b[15:0];
        3'd3: cpu_rdata = {3'b000, mask_b[28:16]};
        3'd4: cpu_rdata = ts_now;
        default: cpu_rdata = '0;
      endcase
    end
  end

  assign bmask     = {{8{cpu_be[1]}}, {8{cpu_be[0]}}};
  assign wr_merged = (cpu_rdata & ~bmask) | (cpu_wdata & bmask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mb       <= '0;
      mask_a   <= '1;
      mask_b   <= '1;
      busy_vld <= 1'b0;
      busy_idx <= '0;
    end else begin
      if (cpu_wr) begin
        if (page < CFG_PAGE) mb[page] <= wr_word(mb[page], word, wr_merged);
        else if (page == CFG_PAGE) begin
          case (word)
            3'd0: mask_a[15:0]  <= wr_merged;
            3'd1: mask_a[28:16] <= wr_merged[12:0];
            3'd2: mask_b[15:0]  <= wr_merged;
            3'd3: mask_b[28:16] <= wr_merged[12:0];
            default: ;
          endcase
        end
      end
      if (rtr_sched) mb[sched_idx].st <= ST_TXPEND;
      if (rx_store) begin
        mb[store_idx].id   <= rx_id;
        mb[store_idx].ide  <= rx_ide;
        mb[store_idx].rtr  <= rx_rtr;
        mb[store_idx].dlc  <= rx_dlc;
        mb[store_idx].data <= rx_data;
        mb[store_idx].ts   <= ts_now;
        mb[store_idx].st   <= ST_FULL;
      end
      if (rx_ovr) mb[ovr_idx].st <= ST_OVR;
      if (tx_launch) begin
        mb[sel_idx].st <= ST_TXBUSY;
        busy_vld       <= 1'b1;
        busy_idx       <= sel_idx;
      end
      if (tx_finish) begin
        mb[busy_idx].ts <= ts_now;
        mb[busy_idx].st <= ST_EMPTY;
        if (mb[busy_idx].rtr && mb[busy_idx].autor) mb[busy_idx].dir <= 1'b0;
        busy_vld <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/can_mbuf_mgr_chk.sv
module can_mbuf_mgr_chk #(
  parameter int TSW = 16
) (
  input logic           clk,
  input logic           rst_n,
  input logic           rx_valid,
  input logic           rx_store,
  input logic           rx_ovr,
  input logic           rtr_sched,
  input logic           tx_req,
  input logic           tx_start,
  input logic           tx_done,
  input logic           busy_vld,
  input logic [28:0]    tx_id,
  input logic [TSW-1:0] ts_now
);
  AST_EVENT_NEEDS_FRAME: assert property (@(posedge clk) disable iff (!rst_n) (rx_store || rx_ovr || rtr_sched) |-> rx_valid); // R4
  AST_DROP_NOT_STORE: assert property (@(posedge clk) disable iff (!rst_n) rx_ovr |-> !rx_store); // R5
  AST_NO_REQ_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n) busy_vld |-> !tx_req); // R6
  AST_START_MAKES_BUSY: assert property (@(posedge clk) disable iff (!rst_n) (tx_req && tx_start) |=> busy_vld); // R7
  AST_FRAME_HELD: assert property (@(posedge clk) disable iff (!rst_n) (busy_vld && !tx_done) |=> $stable(tx_id)); // R7
  AST_DONE_RELEASES: assert property (@(posedge clk) disable iff (!rst_n) (busy_vld && tx_done) |=> !busy_vld); // R7
  AST_REMOTE_DIVERTED: assert property (@(posedge clk) disable iff (!rst_n) rtr_sched |-> !rx_store); // R9
  AST_STAMP_STEPS: assert property (@(posedge clk) disable iff (!rst_n) $past(rst_n) |-> ts_now == TSW'($past(ts_now) + 1'b1)); // R10
endmodule

bind can_mbuf_mgr can_mbuf_mgr_chk #(.TSW(16)) i_chk (
  .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_store(rx_store), .rx_ovr(rx_ovr),
  .rtr_sched(rtr_sched), .tx_req(tx_req), .tx_start(tx_start), .tx_done(tx_done),
  .busy_vld(busy_vld), .tx_id(tx_id), .ts_now(ts_now));

// File: tb/test_can_mbuf_mgr.sv
module test_can_mbuf_mgr;
  localparam int CLK_PERIOD = 10;

  logic        clk = 0, rst_n = 0;
  logic [6:0]  cpu_addr = 0;
  logic        cpu_wr = 0;
  logic [1:0]  cpu_be = 0;
  logic [15:0] cpu_wdata = 0, cpu_rdata;
  logic        rx_valid = 0, rx_ide = 0, rx_rtr = 0;
  logic [28:0] rx_id = 0;
  logic [3:0]  rx_dlc = 0;
  logic [63:0] rx_data = 0;
  logic        tx_req, tx_ide, tx_rtr, tx_start = 0, tx_done = 0;
  logic [28:0] tx_id;
  logic [3:0]  tx_dlc;
  logic [63:0] tx_data;
  int          nchk = 0, nerr = 0;
  logic [15:0] bc;
  logic        wd = 0;

  can_mbuf_mgr i_can_mbuf_mgr (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  // independent model of the free-running stamp
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) bc <= '0; else bc <= bc + 1'b1;

  function automatic logic [6:0] ad(input int b, input int w);
    return {b[3:0], w[2:0]};
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [6:0] a, input logic [15:0] d, input logic [1:0] be = 2'b11);
    @(negedge clk);
    cpu_addr = a; cpu_wdata = d; cpu_be = be; cpu_wr = 1;
    @(negedge clk);
    cpu_wr = 0;
  endtask

  task automatic rd(input logic [6:0] a, output logic [15:0] d);
    @(negedge clk);
    cpu_addr = a;
    #1 d = cpu_rdata;
  endtask

  task automatic cfg(input int b, input logic [28:0] id, input logic ide, input logic rtr,
                     input logic dir, input logic [63:0] data, input logic [15:0] w6);
    wr(ad(b,0), id[15:0]);
    wr(ad(b,1), {rtr, ide, dir, id[28:16]});
    for (int k = 0; k < 4; k++) wr(ad(b,2+k), data[16*k +: 16]);
    wr(ad(b,6), w6);
  endtask

  task automatic frame(input logic [28:0] id, input logic ide, input logic rtr,
                       input logic [63:0] data, output logic [15:0] stamp);
    @(negedge clk);
    rx_id = id; rx_ide = ide; rx_rtr = rtr; rx_dlc = 4'd8; rx_data = data; rx_valid = 1;
    stamp = bc;
    @(negedge clk);
    rx_valid = 0;
  endtask

  task automatic pulse_start();
    @(negedge clk); tx_start = 1;
    @(negedge clk); tx_start = 0;
  endtask

  task automatic pulse_done(output logic [15:0] stamp);
    @(negedge clk); tx_done = 1; stamp = bc;
    @(negedge clk); tx_done = 0;
  endtask

  task automatic st_is(input string req, input int b, input logic [2:0] exp);
    logic [15:0] d;
    rd(ad(b,6), d);
    chk(req, d[2:0], exp);
  endtask

  task automatic t_reset();
    logic [15:0] d;
    st_is("R2 reset buf0 empty", 0, 3'd0);
    rd(ad(14,1), d); chk("R2 reset buf14 receive dir", d[13], 1'b0);
    rd(ad(15,0), d); chk("R2 mask A ones", d, 16'hFFFF);
    rd(ad(15,3), d); chk("R2 mask B ones", d, 16'h1FFF);
    chk("R6 no tx_req after reset", tx_req, 1'b0);
    wr(ad(0,2), 16'hAAAA);
    wr(ad(0,2), 16'h0055, 2'b01);
    rd(ad(0,2), d); chk("R1 low byte write", d, 16'hAA55);
    wr(ad(0,2), 16'h1100, 2'b10);
    rd(ad(0,2), d); chk("R1 high byte write", d, 16'h1155);
  endtask

  task automatic t_store_overrun();
    logic [15:0] d, s;
    cfg(2, 29'h1234567, 1, 0, 0, 0, 16'h0000);
    cfg(5, 29'h1234567, 1, 0, 0, 0, 16'h0000);
    frame(29'h1234567, 1, 0, 64'h0807060504030201, s);
    st_is("R4 lowest buffer full", 2, 3'd1);
    st_is("R4 higher buffer still empty", 5, 3'd0);
    rd(ad(2,2), d); chk("R4 data stored", d, 16'h0201);
    rd(ad(2,7), d); chk("R10 rx stamp", d, s);
    frame(29'h1234567, 1, 0, 64'h1111, s);
    st_is("R4 next free buffer full", 5, 3'd1);
    frame(29'h1234567, 1, 0, 64'h2222, s);
    st_is("R5 overrun on lowest", 2, 3'd2);
    rd(ad(2,2), d); chk("R5 contents kept", d, 16'h0201);
    st_is("R5 other buffer untouched", 5, 3'd1);
  endtask

  task automatic t_masks();
    logic [15:0] d, s;
    wr(ad(15,0), 16'hFFF0);
    cfg(7, 29'h0ABCDE0, 1, 0, 0, 0, 16'h0000);
    frame(29'h0ABCDE5, 1, 0, 64'h3, s);
    st_is("R3 masked bits ignored", 7, 3'd1);
    rd(ad(7,0), d); chk("R4 received id stored", d, 16'hCDE5);
    wr(ad(15,2), 16'h0000); wr(ad(15,3), 16'h0000);
    frame(29'h055 << 18, 0, 0, 64'h4, s);
    st_is("R3 basic path catches", 14, 3'd1);
    wr(ad(15,2), 16'hFFFF); wr(ad(15,3), 16'h1FFF);
    cfg(3, 29'h123 << 18, 0, 0, 0, 0, 16'h0000);
    frame((29'h123 << 18) | 29'h100, 0, 0, 64'h5, s);
    st_is("R11 standard compare bits 28:18 only", 3, 3'd1);
    frame((29'h123 << 18), 1, 0, 64'h6, s);
    st_is("R3 ide mismatch rejected", 3, 3'd1);
  endtask

  task automatic t_tx_prio();
    logic [15:0] d, s;
    cfg(9,  29'h0333333, 1, 0, 1, 64'h9, 16'h5083);
    cfg(4,  29'h0222222, 1, 0, 1, 64'h4, 16'h5083);
    cfg(11, 29'h0111111, 1, 0, 1, 64'hB, 16'h2083);
    @(negedge clk);
    chk("R6 tx_req raised", tx_req, 1'b1);
    chk("R6 smallest prio offered", tx_id, 29'h0111111);
    chk("R6 offered data", tx_data, 64'hB);
    pulse_start();
    chk("R6 tx_req low while busy", tx_req, 1'b0);
    chk("R7 frame held while busy", tx_id, 29'h0111111);
    st_is("R7 busy status", 11, 3'd4);
    pulse_done(s);
    st_is("R7 empty after done", 11, 3'd0);
    rd(ad(11,7), d); chk("R7 tx stamp", d, s);
    @(negedge clk);
    chk("R6 tie to lower index", tx_id, 29'h0222222);
    pulse_start(); pulse_done(s);
    @(negedge clk);
    chk("R6 last pending", tx_id, 29'h0333333);
    pulse_start(); pulse_done(s);
    @(negedge clk);
    chk("R6 nothing pending", tx_req, 1'b0);
  endtask

  task automatic t_remote_sent();
    logic [15:0] d, s;
    cfg(10, 29'h1555AAA, 1, 1, 1, 0, 16'h0803);
    @(negedge clk);
    chk("R8 remote frame offered", tx_rtr, 1'b1);
    pulse_start(); pulse_done(s);
    rd(ad(10,1), d); chk("R8 became receive", d[13], 1'b0);
    st_is("R8 empty after remote sent", 10, 3'd0);
    frame(29'h1555AAA, 1, 0, 64'h77, s);
    st_is("R8 reply captured", 10, 3'd1);
  endtask

  task automatic t_remote_reply();
    logic [15:0] s;
    cfg(12, 29'h0F0F0F0, 1, 0, 1, 64'hBEEF, 16'h0820);
    cfg(13, 29'h0F0F0F0, 1, 0, 0, 0, 16'h0000);
    @(negedge clk);
    chk("R9 idle before remote", tx_req, 1'b0);
    frame(29'h0F0F0F0, 1, 1, 64'h0, s);
    st_is("R9 answer scheduled", 12, 3'd3);
    st_is("R9 remote not stored", 13, 3'd0);
    @(negedge clk);
    chk("R9 answer offered", tx_id, 29'h0F0F0F0);
    chk("R9 answer is data frame", tx_rtr, 1'b0);
    pulse_start(); pulse_done(s);
  endtask

  task automatic t_stamp();
    logic [15:0] d;
    rd(ad(15,4), d); chk("R10 counter value", d, bc);
    repeat (3) @(negedge clk);
    rd(ad(15,4), d); chk("R10 counter advances", d, bc);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    fork
      begin
        t_reset();
        t_store_overrun();
        t_masks();
        t_tx_prio();
        t_remote_sent();
        t_remote_reply();
        t_stamp();
      end
      begin
        repeat (50000) @(posedge clk);
        wd = 1;
      end
    join_any
    if (wd) begin
      nerr++; nchk++;
      $display("FAIL watchdog actual=hung expected=done");
    end
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule